// File: doc/BRIEF.md
# I2C Bus-Hang Recovery Unit

This block frees an I2C bus that a slave has left stuck in the middle of a transfer, typically by holding SDA low while it waits for clock edges that never arrive. A trigger starts the recovery. From the next cycle until recovery ends, the unit holds the main bus controller in reset. It releases both bus lines and waits a settle window. It then reads the synchronized SCL and SDA levels. If either line is low, it drives SCL low for a fixed number of system-clock cycles, releases it, waits the settle window again and repeats the check. Each clock pulse lets a stuck slave shift out one more bit, until it lets go of SDA.

The loop ends as soon as both lines read high, or when the attempt limit has been used up. The unit then lets go of the controller reset. In that same cycle it gives a one-cycle request for the controller to reinitialize its state: clear status, reload its clock divider and set up its interrupts again. A done flag and a fail flag report the outcome. Both flags stay valid until the next recovery is accepted. SDA is never driven by this unit.

Top module: `i2c_hang_recovery`

## Requirements
- R1: While reset is asserted, and after it is released, the unit is idle: `scl_drv_low_o`, `sda_drv_low_o`, `ctrl_rst_o`, `reinit_o`, `done_o` and `fail_o` are all 0.
- R2: A `start_i` pulse seen while idle raises `ctrl_rst_o` on the next clock edge. `ctrl_rst_o` stays 1 for the whole recovery and falls only when recovery ends. SCL is never pulled low unless `ctrl_rst_o` is 1.
- R3: The bus counts as free only when the synchronized SCL and SDA both read 1. If it is free at the first check, recovery ends with zero SCL pulses, `done_o`=1 and `fail_o`=0.
- R4: The first action after a start releases both lines. For the first SETTLE_CYC+1 cycles of recovery `scl_drv_low_o`=0, and `sda_drv_low_o` is 0 at all times.
- R5: Each SCL pulse holds `scl_drv_low_o`=1 for exactly PULSE_CYC cycles. Every pulse is preceded by exactly SETTLE_CYC+1 released cycles: the settle window plus one check cycle.
- R6: At most MAX_TRIES pulses are made. The free check runs before each pulse, so recovery stops after the first settle window in which the bus reads free. A slave that needs N≤MAX_TRIES clocks gets exactly N pulses.
- R7: `done_o` is set when recovery ends. `fail_o` is set with it if the bus still reads busy at the check after the last allowed pulse. Both clear when a new recovery is accepted and otherwise hold their value.
- R8: `reinit_o` is a single-cycle pulse in the first cycle in which `ctrl_rst_o` is 0 again after recovery. There is exactly one such pulse per recovery.
- R9: `start_i` has no effect while a recovery is running. The pulse count and the outcome are unchanged, and only one reinit pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Recovery trigger, sampled while idle |
| scl_i | input | 1 | SCL level read from the pad (asynchronous) |
| sda_i | input | 1 | SDA level read from the pad (asynchronous) |
| scl_drv_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drv_low_o | output | 1 | 1 pulls SDA low, 0 releases it (always released) |
| ctrl_rst_o | output | 1 | Holds the main bus controller in reset |
| reinit_o | output | 1 | One-cycle request to reinitialize the controller |
| done_o | output | 1 | Last recovery has finished |
| fail_o | output | 1 | Last recovery ended with the bus still busy |

## Verification
The bench uses a slave model that keeps SDA low until it has seen a chosen number of SCL releases. This model probes the exact limit boundary. N equal to MAX_TRIES must succeed with MAX_TRIES pulses. MAX_TRIES+1 must fail after the same number of pulses. A design that tests the limit before the free check would report a false failure at the boundary. A design with an off-by-one counter would emit one pulse too many or too few.

A stuck-low SCL with SDA high shows whether both lines are required for a free bus. A design that looks only at SDA would stop at once. Pulse widths and released gaps are measured on every pulse, which exposes a timer that is one cycle short or one cycle long. A trigger injected mid-recovery would give a second reinit pulse or a restarted count in a design that does not ignore it. A reset in the middle of pulsing must drop every output at once.

// File: rtl/hrec_pkg.sv
package hrec_pkg;
  typedef enum logic [2:0] {
    HR_IDLE    = 3'd0,
    HR_RELEASE = 3'd1,
    HR_CHECK   = 3'd2,
    HR_PULSE   = 3'd3,
    HR_DONE    = 3'd4
  } hrec_state_e;
endpackage

// File: rtl/hrec_sync.sv
module hrec_sync #(
  parameter int STAGES   = 2,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hrec_timer.sv
module hrec_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/hrec_attempts.sv
module hrec_attempts #(
  parameter int MAX_TRIES = 100,
  localparam int CW = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  logic [CW-1:0] tries_q, tries_d;
  logic          tries_en;

  always_comb begin
    tries_en = clr_i || inc_i;
    tries_d  = clr_i ? '0 : (tries_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tries_q <= '0;
    else if (tries_en) tries_q <= tries_d;
  end

  assign at_limit_o = (tries_q == CW'(MAX_TRIES));
endmodule

// File: rtl/hrec_fsm.sv
module hrec_fsm
  import hrec_pkg::*;
#(
  parameter int PULSE_CYC  = 1000,
  parameter int SETTLE_CYC = 50,
  parameter int TW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          bus_free_i,
  input  logic          tmr_expired_i,
  input  logic          at_limit_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          try_clr_o,
  output logic          try_inc_o,
  output hrec_state_e   state_o,
  output logic          done_o,
  output logic          fail_o
);
  hrec_state_e st_q, st_d;
  logic        done_q, fail_q, done_d, fail_d, stat_en;

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    try_clr_o  = 1'b0;
    try_inc_o  = 1'b0;
    stat_en    = 1'b0;
    done_d     = done_q;
    fail_d     = fail_q;
    unique case (st_q)
      HR_IDLE: begin
        if (start_i) begin
          st_d       = HR_RELEASE;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(SETTLE_CYC - 1);
          try_clr_o  = 1'b1;
          stat_en    = 1'b1;
          done_d     = 1'b0;
          fail_d     = 1'b0;
        end
      end
      HR_RELEASE: begin
        if (tmr_expired_i) st_d = HR_CHECK;
      end
      HR_CHECK: begin
        if (bus_free_i) begin
          st_d    = HR_DONE;
          stat_en = 1'b1;
          done_d  = 1'b1;
          fail_d  = 1'b0;
        end else if (at_limit_i) begin
          st_d    = HR_DONE;
          stat_en = 1'b1;
          done_d  = 1'b1;
          fail_d  = 1'b1;
        end else begin
          st_d       = HR_PULSE;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(PULSE_CYC - 1);
          try_inc_o  = 1'b1;
        end
      end
      HR_PULSE: begin
        if (tmr_expired_i) begin
          st_d       = HR_RELEASE;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(SETTLE_CYC - 1);
        end
      end
      HR_DONE: st_d = HR_IDLE;
      default: st_d = HR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HR_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (stat_en) begin
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;
  assign fail_o  = fail_q;
endmodule

// File: rtl/i2c_hang_recovery.sv
module i2c_hang_recovery
  import hrec_pkg::*;
#(
  parameter int PULSE_CYC   = 1000,
  parameter int SETTLE_CYC  = 50,
  parameter int MAX_TRIES   = 100,
  parameter int SYNC_STAGES = 2,
  localparam int TMAX       = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC,
  localparam int TW         = $clog2(TMAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_drv_low_o,
  output logic sda_drv_low_o,
  output logic ctrl_rst_o,
  output logic reinit_o,
  output logic done_o,
  output logic fail_o
);
  logic          rst_n_s;
  logic          scl_s, sda_s;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          try_clr, try_inc, at_limit;
  hrec_state_e   state;

  hrec_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_n_s)
  );

  hrec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(scl_i), .q_o(scl_s)
  );

  hrec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(sda_i), .q_o(sda_s)
  );

  hrec_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .load_i(tmr_load), .val_i(tmr_val),
    .expired_o(tmr_expired)
  );

  hrec_attempts #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n_s), .clr_i(try_clr), .inc_i(try_inc),
    .at_limit_o(at_limit)
  );

  hrec_fsm #(.PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC), .TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .start_i(start_i),
    .bus_free_i(scl_s & sda_s), .tmr_expired_i(tmr_expired),
    .at_limit_i(at_limit), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .try_clr_o(try_clr), .try_inc_o(try_inc), .state_o(state),
    .done_o(done_o), .fail_o(fail_o)
  );

  assign scl_drv_low_o = (state == HR_PULSE);
  assign sda_drv_low_o = 1'b0;
  assign ctrl_rst_o    = (state == HR_RELEASE) || (state == HR_CHECK) ||
                         (state == HR_PULSE);
  assign reinit_o      = (state == HR_DONE);
endmodule

// File: rtl/hrec_checker.sv
module hrec_checker #(
  parameter int PULSE_CYC = 1000,
  parameter int MAX_TRIES = 100,
  localparam int PW = $clog2(PULSE_CYC + 1),
  localparam int CW = $clog2(MAX_TRIES + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic scl_drv_low_o,
  input logic ctrl_rst_o,
  input logic reinit_o,
  input logic done_o,
  input logic fail_o
);
  logic [PW-1:0] low_run_q;
  logic [CW-1:0] pulses_q;
  logic          scl_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q  <= '0;
      pulses_q   <= '0;
      scl_prev_q <= 1'b0;
    end else begin
      scl_prev_q <= scl_drv_low_o;
      if (scl_drv_low_o && (low_run_q != PW'(PULSE_CYC))) low_run_q <= low_run_q + 1'b1;
      else if (!scl_drv_low_o) low_run_q <= '0;
      if (!ctrl_rst_o) pulses_q <= '0;
      else if (scl_drv_low_o && !scl_prev_q && (pulses_q != CW'(MAX_TRIES + 1)))
        pulses_q <= pulses_q + 1'b1;
    end
  end

  AST_SCL_ONLY_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drv_low_o |-> ctrl_rst_o); // R2
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drv_low_o |-> (low_run_q < PW'(PULSE_CYC))); // R5
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q <= CW'(MAX_TRIES)); // R6
  AST_FAIL_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> done_o); // R7
  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_o) |-> (!done_o && !fail_o)); // R7
  AST_REINIT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rst_o) |-> reinit_o); // R8
  AST_REINIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_o |=> !reinit_o); // R8
endmodule

bind i2c_hang_recovery hrec_checker #(.PULSE_CYC(PULSE_CYC), .MAX_TRIES(MAX_TRIES)) u_hrec_chk (
  .clk(clk), .rst_n(rst_n), .scl_drv_low_o(scl_drv_low_o), .ctrl_rst_o(ctrl_rst_o),
  .reinit_o(reinit_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/i2c_hang_recovery_bench.sv
module i2c_hang_recovery_bench;
  localparam int PULSE  = 8;
  localparam int SETTLE = 4;
  localparam int MAXT   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic scl_stuck = 1'b0;
  logic sda_i = 1'b1;
  logic scl_i;
  logic scl_drv_low_o, sda_drv_low_o, ctrl_rst_o, reinit_o, done_o, fail_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  assign scl_i = !scl_drv_low_o && !scl_stuck;

  i2c_hang_recovery #(.PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE), .MAX_TRIES(MAXT),
                      .SYNC_STAGES(2)) u_i2c_hang_recovery (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_drv_low_o(scl_drv_low_o), .sda_drv_low_o(sda_drv_low_o),
    .ctrl_rst_o(ctrl_rst_o), .reinit_o(reinit_o), .done_o(done_o), .fail_o(fail_o)
  );

  // {hold clocks[7:0], scl stuck[0], expected pulses[7:0], expected fail[0]}
  localparam logic [17:0] VECS [0:6] = '{
    {8'd0,  1'b0, 8'd0, 1'b0},
    {8'd1,  1'b0, 8'd1, 1'b0},
    {8'd3,  1'b0, 8'd3, 1'b0},
    {8'd6,  1'b0, 8'd6, 1'b0},
    {8'd7,  1'b0, 8'd6, 1'b1},
    {8'd20, 1'b0, 8'd6, 1'b1},
    {8'd0,  1'b1, 8'd6, 1'b1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input int hold, input bit stuck, input int exp_p, input bit exp_f,
                     input bit mid_start);
    int pulses = 0, releases = 0, low_run = 0, high_run = 0;
    int bad_w = 0, bad_gap = 0, sda_drv = 0, rst_bad = 0, reinits = 0, k = 0;
    bit prev_low = 0, first_ok = 1, cleared_ok = 1;
    scl_stuck = stuck;
    sda_i = (hold == 0);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (k < 5000) begin
      k++;
      if (k == 1 && (done_o || fail_o)) cleared_ok = 0;
      if (mid_start) start_i = (k == 15);
      if (sda_drv_low_o) sda_drv++;
      if (k <= SETTLE + 1 && scl_drv_low_o) first_ok = 0;
      if (scl_drv_low_o && !ctrl_rst_o) rst_bad++;
      if (reinit_o) begin
        reinits++;
        if (ctrl_rst_o) rst_bad++;
        break;
      end
      if (!ctrl_rst_o) rst_bad++;
      if (scl_drv_low_o) begin
        if (!prev_low) begin
          pulses++;
          if (high_run != SETTLE + 1) bad_gap++;
        end
        low_run++;
      end else begin
        if (prev_low) begin
          releases++;
          if (low_run != PULSE) bad_w++;
          low_run = 0;
          if (releases >= hold) sda_i = 1'b1;
          high_run = 0;
        end
        high_run++;
      end
      prev_low = scl_drv_low_o;
      @(negedge clk);
    end
    start_i = 1'b0;
    @(negedge clk);
    if (reinit_o) reinits++;
    check(cleared_ok, "R7", "status cleared at start", int'(cleared_ok), 1);
    check(first_ok, "R4", "lines released first", int'(first_ok), 1);
    check(sda_drv == 0, "R4", "SDA drive cycles", sda_drv, 0);
    check(rst_bad == 0, "R2", "controller reset framing errors", rst_bad, 0);
    check(pulses == exp_p, exp_p == 0 ? "R3" : "R6", "SCL pulse count", pulses, exp_p);
    check(bad_w == 0, "R5", "pulse width errors", bad_w, 0);
    check(bad_gap == 0, "R5", "released gap errors", bad_gap, 0);
    check(done_o == 1'b1, "R7", "done flag", int'(done_o), 1);
    check(fail_o == exp_f, "R7", "fail flag", int'(fail_o), int'(exp_f));
    check(reinits == 1, mid_start ? "R9" : "R8", "reinit pulses", reinits, 1);
    check(!ctrl_rst_o, "R2", "reset released after end", int'(ctrl_rst_o), 0);
    repeat (3) @(negedge clk);
    check(done_o && (fail_o == exp_f), "R7", "status held", int'(fail_o), int'(exp_f));
    scl_stuck = 1'b0;
    sda_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!scl_drv_low_o && !sda_drv_low_o && !ctrl_rst_o && !reinit_o && !done_o && !fail_o,
          "R1", "outputs during reset", int'(ctrl_rst_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!scl_drv_low_o && !ctrl_rst_o && !reinit_o && !done_o && !fail_o,
          "R1", "idle after reset", int'(done_o), 0);

    for (int i = 0; i < 7; i++) begin
      run(int'(VECS[i][17:10]), VECS[i][9], int'(VECS[i][8:1]), VECS[i][0], 1'b0);
    end

    // R9: trigger repeated during recovery
    run(3, 1'b0, 3, 1'b0, 1'b1);

    // R1: reset in the middle of pulsing
    scl_stuck = 1'b1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!scl_drv_low_o && !ctrl_rst_o && !done_o && !fail_o && !reinit_o,
          "R1", "outputs after mid-run reset", int'(ctrl_rst_o), 0);
    scl_stuck = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run(2, 1'b0, 2, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule